// File: doc/BRIEF.md
# Processor Debug Event Recorder

This block sits beside a simple processor pipeline. It watches the retirement stream, the interrupt-taken strobe and the hit lines of the address comparators, and decides in each cycle which debug events are recognised. Each recognised event sets a sticky status bit. Software clears these bits by writing ones to them.

Trap, branch-taken, instruction-complete and interrupt-taken events can also load a saved program-counter register. Each event type loads a different address. When several events arrive in the same cycle, a fixed priority decides which one loads the register.

Each event type has its own rule for how it depends on the machine-state debug-enable bit and the external-debug-mode bit. A debug-exception strobe is raised for one cycle whenever a new event is recorded while debug-enable is set.

Top module: `dbg_event_rec`

## Requirements
- R1: A trap event sets status bit 0 when `enTrap` is high and a retirement of class 1 (trap) has `retCond` high. This happens whatever the values of `msrDe` and `edm`. The event loads `retPc` into `savedPc`.
- R2: A branch-taken event sets status bit 1 and loads `retPc` into `savedPc`. It needs all of the following: `enBrt` high, a retirement of class 2 (branch) with `retCond` high (the branch is taken), and `msrDe` or `edm` high. A branch that is not taken is never recorded. A taken branch is not recorded when both `msrDe` and `edm` are low.
- R3: An instruction-complete event sets status bit 2 and loads `retNextPc` into `savedPc`. It needs all of the following: `enIcmp` high, a retirement with `retSuppressed` low, and `msrDe` or `edm` high. A retirement of class 3 (system call) that is not suppressed still counts.
- R4: A retirement with `retSetsDe` high or `retSetsIcmp` high never produces an instruction-complete event.
- R5: When `linkEn` is high, `iacHit` never sets status bit 5. A linked compare, where `dacHit` and `iacHit` are high together, sets status bit 4 whatever the value of `msrDe`. The linked compare is dropped when `mwAbort` is high in the same cycle.
- R6: When `linkEn` is low, `iacHit` sets status bit 5 and `dacHit` sets status bit 4, each on its own.
- R7: An interrupt-taken event sets status bit 3 and loads `irqPc` into `savedPc`. It needs `enIrpt` high and `irqTaken` high with `irqCritical` low. A critical interrupt records nothing.
- R8: Status bits update one clock after their cause and stay set. A bit is cleared only by a cycle with `w1cValid` high and a one in that bit of `w1cMask`. If a bit is set and cleared in the same cycle, the set wins.
- R9: When several events load `savedPc` in the same cycle, the address is taken in this order of priority: trap, branch-taken, instruction-complete, interrupt-taken. A cycle with no such event leaves `savedPc` unchanged.
- R10: `dbgExc` is high for exactly the one cycle after a cycle in which any status bit was newly set while `msrDe` was high. It is low otherwise.
- R11: After reset, `status`, `savedPc` and `dbgExc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enTrap | input | 1 | Trap event enable |
| enBrt | input | 1 | Branch-taken event enable |
| enIcmp | input | 1 | Instruction-complete event enable |
| enIrpt | input | 1 | Interrupt-taken event enable |
| linkEn | input | 1 | Links the data compare to the instruction compare |
| msrDe | input | 1 | Machine-state debug-enable |
| edm | input | 1 | External debug mode |
| retValid | input | 1 | A retirement is presented this cycle |
| retClass | input | 3 | Class: 0 other, 1 trap, 2 branch, 3 system call, 4 multi-word |
| retCond | input | 1 | Trap condition true, or branch taken |
| retSuppressed | input | 1 | Execution suppressed by another enabled exception |
| retSetsDe | input | 1 | Instruction writes debug-enable |
| retSetsIcmp | input | 1 | Instruction writes the completion-event enable |
| retPc | input | AW | Address of the retiring instruction |
| retNextPc | input | AW | Address of the next instruction to execute |
| irqTaken | input | 1 | An interrupt is taken this cycle |
| irqCritical | input | 1 | The interrupt taken is critical |
| irqPc | input | AW | Address saved for the interrupt |
| iacHit | input | 1 | Instruction-address comparator hit |
| dacHit | input | 1 | Data-address comparator hit |
| mwAbort | input | 1 | Multi-word load/store interrupted before completion |
| w1cValid | input | 1 | Write-one-to-clear strobe |
| w1cMask | input | 6 | Status bits to clear |
| status | output | 6 | Sticky event status |
| savedPc | output | AW | Saved program counter |
| dbgExc | output | 1 | One-cycle debug-exception strobe |

## Verification
Each event type is driven in two ways: once with every gating condition met, and once with a single condition removed. The conditions removed include debug-enable, external mode, branch not taken, suppression, the self-setting flags and a critical interrupt. This pinpoints which condition each recognition rule actually depends on.

The comparator patterns work the same way. Linked hits are tried with and without an aborted multi-word access, and unlinked hits are tried on their own, which shows whether the instruction-compare bit is hidden.

Some stimuli combine several causes in one cycle: a trap with an interrupt, and a write-one-to-clear with a new hit. These show the address priority and the set-over-clear rule.

// File: rtl/dbg_event_pkg.sv
package dbg_event_pkg;
  localparam int NUM_EV  = 6;
  localparam int EV_TRAP = 0;
  localparam int EV_BRT  = 1;
  localparam int EV_ICMP = 2;
  localparam int EV_IRPT = 3;
  localparam int EV_DAC  = 4;
  localparam int EV_IAC  = 5;

  typedef enum logic [2:0] {
    CLS_OTHER   = 3'd0,
    CLS_TRAP    = 3'd1,
    CLS_BRANCH  = 3'd2,
    CLS_SYSCALL = 3'd3,
    CLS_MULTI   = 3'd4
  } retClass_e;

  typedef enum logic [1:0] {
    PC_RET  = 2'd0,
    PC_NEXT = 2'd1,
    PC_IRQ  = 2'd2
  } pcSel_e;

  typedef struct packed {
    logic [NUM_EV-1:0] evSet;
    logic              pcLoad;
    pcSel_e            pcSel;
    logic              raise;
  } evStrobe_t;
endpackage

// File: rtl/dbg_event_ctrl.sv
module dbg_event_ctrl
  import dbg_event_pkg::*;
(
  input  logic       enTrap,
  input  logic       enBrt,
  input  logic       enIcmp,
  input  logic       enIrpt,
  input  logic       linkEn,
  input  logic       msrDe,
  input  logic       edm,
  input  logic       retValid,
  input  logic [2:0] retClass,
  input  logic       retCond,
  input  logic       retSuppressed,
  input  logic       retSetsDe,
  input  logic       retSetsIcmp,
  input  logic       irqTaken,
  input  logic       irqCritical,
  input  logic       iacHit,
  input  logic       dacHit,
  input  logic       mwAbort,
  output evStrobe_t  strobe
);
  logic dbgActive;
  logic trapEv, brtEv, icmpEv, irptEv, dacEv, iacEv;

  always_comb begin
    dbgActive = msrDe | edm;
    // Trap ignores the debug-enable bit and external mode.
    trapEv = enTrap & retValid & (retClass == CLS_TRAP) & retCond;
    brtEv  = enBrt & retValid & (retClass == CLS_BRANCH) & retCond & dbgActive;
    // Suppressed instructions never complete. Self-enabling writes are excluded.
    icmpEv = enIcmp & retValid & ~retSuppressed & dbgActive
           & ~retSetsDe & ~retSetsIcmp;
    irptEv = enIrpt & irqTaken & ~irqCritical;
    if (linkEn) begin
      dacEv = dacHit & iacHit & ~mwAbort;
      iacEv = 1'b0;
    end else begin
      dacEv = dacHit;
      iacEv = iacHit;
    end

    strobe = '0;
    strobe.evSet[EV_TRAP] = trapEv;
    strobe.evSet[EV_BRT]  = brtEv;
    strobe.evSet[EV_ICMP] = icmpEv;
    strobe.evSet[EV_IRPT] = irptEv;
    strobe.evSet[EV_DAC]  = dacEv;
    strobe.evSet[EV_IAC]  = iacEv;
    strobe.pcLoad = trapEv | brtEv | icmpEv | irptEv;
    if (trapEv || brtEv) strobe.pcSel = PC_RET;
    else if (icmpEv)     strobe.pcSel = PC_NEXT;
    else                 strobe.pcSel = PC_IRQ;
    strobe.raise = msrDe & (|strobe.evSet);
  end
endmodule

// File: rtl/dbg_event_dp.sv
module dbg_event_dp
  import dbg_event_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evStrobe_t         strobe,
  input  logic [AW-1:0]     retPc,
  input  logic [AW-1:0]     retNextPc,
  input  logic [AW-1:0]     irqPc,
  input  logic              w1cValid,
  input  logic [NUM_EV-1:0] w1cMask,
  output logic [NUM_EV-1:0] status,
  output logic [AW-1:0]     savedPc,
  output logic              dbgExc
);
  logic [NUM_EV-1:0] clrMask;
  logic [AW-1:0]     pcMux;

  always_comb begin
    clrMask = w1cValid ? w1cMask : '0;
    case (strobe.pcSel)
      PC_RET:  pcMux = retPc;
      PC_NEXT: pcMux = retNextPc;
      default: pcMux = irqPc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      savedPc <= '0;
      dbgExc  <= 1'b0;
    end else begin
      status <= (status & ~clrMask) | strobe.evSet;
      if (strobe.pcLoad) savedPc <= pcMux;
      dbgExc <= strobe.raise;
    end
  end
endmodule

// File: rtl/dbg_event_rec.sv
module dbg_event_rec
  import dbg_event_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enTrap,
  input  logic              enBrt,
  input  logic              enIcmp,
  input  logic              enIrpt,
  input  logic              linkEn,
  input  logic              msrDe,
  input  logic              edm,
  input  logic              retValid,
  input  logic [2:0]        retClass,
  input  logic              retCond,
  input  logic              retSuppressed,
  input  logic              retSetsDe,
  input  logic              retSetsIcmp,
  input  logic [AW-1:0]     retPc,
  input  logic [AW-1:0]     retNextPc,
  input  logic              irqTaken,
  input  logic              irqCritical,
  input  logic [AW-1:0]     irqPc,
  input  logic              iacHit,
  input  logic              dacHit,
  input  logic              mwAbort,
  input  logic              w1cValid,
  input  logic [NUM_EV-1:0] w1cMask,
  output logic [NUM_EV-1:0] status,
  output logic [AW-1:0]     savedPc,
  output logic              dbgExc
);
  evStrobe_t strobe;

  dbg_event_ctrl u_ctrl (
    .enTrap(enTrap), .enBrt(enBrt), .enIcmp(enIcmp), .enIrpt(enIrpt),
    .linkEn(linkEn), .msrDe(msrDe), .edm(edm), .retValid(retValid),
    .retClass(retClass), .retCond(retCond), .retSuppressed(retSuppressed),
    .retSetsDe(retSetsDe), .retSetsIcmp(retSetsIcmp), .irqTaken(irqTaken),
    .irqCritical(irqCritical), .iacHit(iacHit), .dacHit(dacHit),
    .mwAbort(mwAbort), .strobe(strobe)
  );

  dbg_event_dp #(.AW(AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .retPc(retPc),
    .retNextPc(retNextPc), .irqPc(irqPc), .w1cValid(w1cValid),
    .w1cMask(w1cMask), .status(status), .savedPc(savedPc), .dbgExc(dbgExc)
  );
endmodule

// File: rtl/dbg_event_rec_chk.sv
module dbg_event_rec_chk
  import dbg_event_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enTrap,
  input logic              enBrt,
  input logic              enIcmp,
  input logic              linkEn,
  input logic              msrDe,
  input logic              edm,
  input logic              retValid,
  input logic [2:0]        retClass,
  input logic              retCond,
  input logic              retSetsDe,
  input logic [AW-1:0]     retPc,
  input logic              iacHit,
  input logic              w1cValid,
  input logic [NUM_EV-1:0] status,
  input logic [AW-1:0]     savedPc,
  input logic              dbgExc
);
  // R1
  trap_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enTrap && retValid && retClass == CLS_TRAP && retCond |=> status[EV_TRAP]);

  // R2
  branch_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enBrt && retValid && retClass == CLS_BRANCH && retCond && (msrDe || edm)
    |=> savedPc == $past(retPc));

  // R4
  self_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retValid && enIcmp && retSetsDe && !status[EV_ICMP] && !w1cValid
    |=> !status[EV_ICMP]);

  // R5
  linked_iac_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linkEn && iacHit && !status[EV_IAC] |=> !status[EV_IAC]);

  // R8
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !w1cValid |=> (status & $past(status)) == $past(status));

  // R10
  exc_needs_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbgExc |-> $past(msrDe));
endmodule

bind dbg_event_rec dbg_event_rec_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enTrap(enTrap), .enBrt(enBrt), .enIcmp(enIcmp),
  .linkEn(linkEn), .msrDe(msrDe), .edm(edm), .retValid(retValid),
  .retClass(retClass), .retCond(retCond), .retSetsDe(retSetsDe),
  .retPc(retPc), .iacHit(iacHit), .w1cValid(w1cValid), .status(status),
  .savedPc(savedPc), .dbgExc(dbgExc)
);

// File: tb/dbg_event_rec_bench.sv
`timescale 1ns/1ps
module dbg_event_rec_bench;
  localparam int AW = 32;
  localparam int NE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enTrap, enBrt, enIcmp, enIrpt, linkEn, msrDe, edm;
  logic retValid, retCond, retSuppressed, retSetsDe, retSetsIcmp;
  logic [2:0] retClass;
  logic [AW-1:0] retPc, retNextPc, irqPc;
  logic irqTaken, irqCritical, iacHit, dacHit, mwAbort, w1cValid;
  logic [NE-1:0] w1cMask;
  logic [NE-1:0] status;
  logic [AW-1:0] savedPc;
  logic dbgExc;

  int tests = 0;
  int fails = 0;

  logic [NE-1:0] expStatus = '0;
  logic [AW-1:0] expPc = '0;
  logic [NE-1:0] qStatus[$];
  logic [AW-1:0] qPc[$];
  logic          qExc[$];
  string         qReq[$];

  always #4 clk = ~clk;

  dbg_event_rec #(.AW(AW)) u_dbg_event_rec (.*);

  task automatic idle();
    retValid = 0; retClass = 3'd0; retCond = 0; retSuppressed = 0;
    retSetsDe = 0; retSetsIcmp = 0; irqTaken = 0; irqCritical = 0;
    iacHit = 0; dacHit = 0; mwAbort = 0; w1cValid = 0; w1cMask = '0;
  endtask

  // Driver: compute expected results from the requirements, queue them, apply one cycle.
  task automatic step(input string req);
    logic [NE-1:0] nw;
    logic t, b, c, i;
    t = enTrap && retValid && retClass == 3'd1 && retCond;
    b = enBrt && retValid && retClass == 3'd2 && retCond && (msrDe || edm);
    c = enIcmp && retValid && !retSuppressed && (msrDe || edm) && !retSetsDe && !retSetsIcmp;
    i = enIrpt && irqTaken && !irqCritical;
    nw = '0;
    nw[0] = t; nw[1] = b; nw[2] = c; nw[3] = i;
    nw[4] = linkEn ? (dacHit && iacHit && !mwAbort) : dacHit;
    nw[5] = !linkEn && iacHit;
    expStatus = (expStatus & ~(w1cValid ? w1cMask : '0)) | nw;
    if (t || b) expPc = retPc;
    else if (c) expPc = retNextPc;
    else if (i) expPc = irqPc;
    qStatus.push_back(expStatus);
    qPc.push_back(expPc);
    qExc.push_back(msrDe && (|nw));
    qReq.push_back(req);
    @(negedge clk);
    idle();
  endtask

  // Monitor: compare after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (qReq.size() > 0) begin
        logic [NE-1:0] s; logic [AW-1:0] p; logic e; string r;
        s = qStatus.pop_front(); p = qPc.pop_front();
        e = qExc.pop_front(); r = qReq.pop_front();
        tests++;
        if (status !== s || savedPc !== p || dbgExc !== e) begin
          fails++;
          $display("FAIL %s: status=%b pc=%h exc=%b expected status=%b pc=%h exc=%b",
                   r, status, savedPc, dbgExc, s, p, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    enTrap = 1; enBrt = 1; enIcmp = 0; enIrpt = 1; linkEn = 0; msrDe = 0; edm = 0;
    retPc = '0; retNextPc = '0; irqPc = '0;
    idle();
    repeat (3) @(negedge clk);
    tests++;
    if (status !== '0 || savedPc !== '0 || dbgExc !== 1'b0) begin
      fails++;
      $display("FAIL R11: status=%b pc=%h exc=%b expected all zero", status, savedPc, dbgExc);
    end
    rst_n = 1;
    @(negedge clk);

    // R1: trap recorded with debug disabled, no strobe
    retValid = 1; retClass = 3'd1; retCond = 1; retPc = 32'h1000; step("R1 trap");
    // R8: write-one-to-clear
    w1cValid = 1; w1cMask = 6'b000001; step("R8 clear");
    // R2: taken branch without debug or external mode: nothing
    retValid = 1; retClass = 3'd2; retCond = 1; retPc = 32'h2000; step("R2 no mode");
    edm = 1;
    retValid = 1; retClass = 3'd2; retCond = 1; retPc = 32'h2004; step("R2 edm taken");
    edm = 0; msrDe = 1;
    retValid = 1; retClass = 3'd2; retCond = 0; retPc = 32'h2008; step("R2 not taken");
    w1cValid = 1; w1cMask = '1; step("R8 clear all");
    // R3 / R10: completion with debug enabled
    enIcmp = 1;
    retValid = 1; retPc = 32'h3000; retNextPc = 32'h3004; step("R3 R10 complete");
    w1cValid = 1; w1cMask = '1; step("R8 clear");
    retValid = 1; retSuppressed = 1; retNextPc = 32'h3008; step("R3 suppressed");
    retValid = 1; retClass = 3'd3; retPc = 32'h3100; retNextPc = 32'h3104; step("R3 syscall");
    w1cValid = 1; w1cMask = '1; step("R8 clear");
    // R4
    retValid = 1; retSetsDe = 1; retNextPc = 32'h3200; step("R4 sets de");
    retValid = 1; retSetsIcmp = 1; retNextPc = 32'h3300; step("R4 sets icmp");
    enIcmp = 0; msrDe = 0;
    // R7
    irqTaken = 1; irqCritical = 1; irqPc = 32'h4000; step("R7 critical");
    irqTaken = 1; irqPc = 32'h4100; step("R7 noncritical");
    w1cValid = 1; w1cMask = '1; step("R8 clear");
    // R5 / R6
    linkEn = 1;
    iacHit = 1; dacHit = 1; step("R5 linked");
    w1cValid = 1; w1cMask = '1; step("R8 clear");
    iacHit = 1; dacHit = 1; mwAbort = 1; step("R5 aborted");
    iacHit = 1; step("R5 iac hidden");
    linkEn = 0;
    iacHit = 1; step("R6 iac");
    dacHit = 1; msrDe = 1; step("R6 R10 dac");
    msrDe = 0;
    // R9: trap beats interrupt
    retValid = 1; retClass = 3'd1; retCond = 1; retPc = 32'h5000;
    irqTaken = 1; irqPc = 32'h5100; step("R9 priority");
    // R8: set wins over clear
    w1cValid = 1; w1cMask = '1; dacHit = 1; step("R8 set wins");
    step("R9 idle keeps pc");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule